// File: doc/BRIEF.md
# Per-core power domain sequencer

This block controls the power domains of a small group of CPU cores, arranged as clusters of cores. Software writes a requested state for one core (on or off) through a simple register port. The block queues each request and works through the queue strictly in arrival order, one core at a time. For each request it drives that core's isolation, clamp and power-switch enables through a fixed multi-step sequence. A software-programmable wait separates each step from the next.

A power-off request is held until the target core reports that it is idle, waiting for an interrupt. If a power-on request for the same core arrives while the power-off is still held, the power-off is abandoned and the core stays powered. Each core's actual state can be read back at any time through the same register port as a two-bit code: on, off, powering up or powering down.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core reads status 0x3, `pwr_en_o` is all ones, `iso_o` and `clamp_o` are all zeros, the overflow flag is 0 and the step wait equals `WAIT_INIT` (4).
- R2: Core n = cluster*CORES_PER_CLUSTER + core sits at address n (0..3). A write to it sets the requested state from wdata bits [1:0], where 0x3 means on and 0x0 means off. The values 0x1 and 0x2 are ignored. A read returns the status in bits [1:0] and zero above. Addresses above 4 read zero.
- R3: A power-off request that reaches the head of the queue changes nothing on that core (status stays 0x3, isolation low) until that core's `wfi_i` is high at a clock edge.
- R4: On the WFI edge the status becomes 0x2 and isolation asserts. W cycles later the clamp asserts. W cycles after that the power switch opens. After W more cycles the status becomes 0x0. A wait of 0 behaves as 1.
- R5: A power-on request sets status 0x1 and closes the switch. After W cycles the clamp is released. After W more cycles isolation is released and the status becomes 0x3.
- R6: Requests are serviced one at a time in the order written. A request for one core does not start while an earlier request for another core is still pending.
- R7: A write whose target equals the core's current status, while no request for that core is queued, takes no queue entry.
- R8: The queue holds 8 requests. A request written while it is full is dropped with no effect and sets a sticky overflow flag in bit 8 of address 4. Only reset clears the flag.
- R9: While a power-off waits for WFI, a later queued power-on for the same core cancels it. The core stays at status 0x3 and is not sequenced.
- R10: Address 4 bits [7:0] hold the step wait W. A write to address 4 sets W, and a read returns W and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W (4) | Register address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| wfi_i | input | NUM_CORES (4) | Per-core wait-for-interrupt indication |
| iso_o | output | NUM_CORES (4) | Per-core isolation enable |
| clamp_o | output | NUM_CORES (4) | Per-core output clamp enable |
| pwr_en_o | output | NUM_CORES (4) | Per-core power switch closed |

## Verification
The hardest conditions to reach are a full queue and a cancelled power-off, because the queue normally drains within a few cycles. The bench holds `wfi_i` low on the core at the head, so a power-off parks the sequencer. While it is parked, the bench stacks alternating off and on requests for a second core until the queue is full. It then adds redundant writes, which must not count as entries, and one further write, which must set the overflow flag. Releasing WFI then drains the queue through a chain of cancellations and immediate completions. A reference model that updates on every clock follows the whole drain.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;
  localparam logic [1:0] PWR_OFF = 2'b00;
  localparam logic [1:0] PWR_UP  = 2'b01;
  localparam logic [1:0] PWR_DN  = 2'b10;
  localparam logic [1:0] PWR_ON  = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WFI,
    SQ_DN_ISO,
    SQ_DN_CLAMP,
    SQ_DN_SW,
    SQ_UP_SW,
    SQ_UP_CLAMP
  } seq_state_e;
endpackage

// File: rtl/core_pwr_queue.sv
module core_pwr_queue #(
  parameter int NUM_CORES = 4,
  parameter int DEPTH     = 8,
  parameter int IDX_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic [IDX_W-1:0]     push_core_i,
  input  logic                 push_on_i,
  input  logic                 pop_i,
  output logic                 full_o,
  output logic                 empty_o,
  output logic [IDX_W-1:0]     head_core_o,
  output logic                 head_on_o,
  output logic [NUM_CORES-1:0] core_hit_o,
  output logic [NUM_CORES-1:0] later_on_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [IDX_W-1:0] core_mem [DEPTH];
  logic [DEPTH-1:0] on_mem;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign full_o  = cnt_q == CNT_W'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_core_o = core_mem[rd_ptr];
  assign head_on_o   = on_mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
      on_mem <= '0;
    end else begin
      if (push_ok) begin
        on_mem[wr_ptr] <= push_on_i;
        wr_ptr         <= wr_ptr + 1'b1;
      end
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) core_mem[wr_ptr] <= push_core_i;
  end

  // occupancy scan: any entry per core, and any power-on behind the head
  always_comb begin
    core_hit_o = '0;
    later_on_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] off;
      off = PTR_W'(i) - rd_ptr;
      if ({1'b0, off} < cnt_q) begin
        core_hit_o[core_mem[i]] = 1'b1;
        if (off != '0 && on_mem[i]) later_on_o[core_mem[i]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  parameter int WAIT_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      q_empty_i,
  input  logic [IDX_W-1:0]          head_core_i,
  input  logic                      head_on_i,
  input  logic [NUM_CORES-1:0]      later_on_i,
  input  logic [NUM_CORES-1:0]      wfi_i,
  input  logic [WAIT_W-1:0]         wait_i,
  output logic                      pop_o,
  output logic [NUM_CORES-1:0][1:0] status_o,
  output logic [NUM_CORES-1:0]      iso_o,
  output logic [NUM_CORES-1:0]      clamp_o,
  output logic [NUM_CORES-1:0]      pwr_en_o
);
  seq_state_e st_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [1:0] head_tgt;
  logic step_done;

  assign head_tgt  = head_on_i ? PWR_ON : PWR_OFF;
  // zero wait acts as one cycle
  assign step_done = ({1'b0, cnt_q} + (WAIT_W+1)'(1)) >= {1'b0, wait_i};

  always_comb begin
    pop_o = 1'b0;
    unique case (st_q)
      SQ_IDLE:                pop_o = !q_empty_i && (status_o[head_core_i] == head_tgt);
      SQ_WFI:                 pop_o = later_on_i[head_core_i];
      SQ_DN_SW, SQ_UP_CLAMP:  pop_o = step_done;
      default:                pop_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      status_o <= {NUM_CORES{PWR_ON}};
      iso_o    <= '0;
      clamp_o  <= '0;
      pwr_en_o <= '1;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (!q_empty_i && status_o[head_core_i] != head_tgt) begin
            if (head_on_i) begin
              status_o[head_core_i] <= PWR_UP;
              pwr_en_o[head_core_i] <= 1'b1;
              cnt_q <= '0;
              st_q  <= SQ_UP_SW;
            end else begin
              st_q <= SQ_WFI;
            end
          end
        end
        SQ_WFI: begin
          if (later_on_i[head_core_i]) begin
            st_q <= SQ_IDLE;
          end else if (wfi_i[head_core_i]) begin
            status_o[head_core_i] <= PWR_DN;
            iso_o[head_core_i]    <= 1'b1;
            cnt_q <= '0;
            st_q  <= SQ_DN_ISO;
          end
        end
        SQ_DN_ISO: begin
          if (step_done) begin
            clamp_o[head_core_i] <= 1'b1;
            cnt_q <= '0;
            st_q  <= SQ_DN_CLAMP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_DN_CLAMP: begin
          if (step_done) begin
            pwr_en_o[head_core_i] <= 1'b0;
            cnt_q <= '0;
            st_q  <= SQ_DN_SW;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_DN_SW: begin
          if (step_done) begin
            status_o[head_core_i] <= PWR_OFF;
            st_q <= SQ_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_UP_SW: begin
          if (step_done) begin
            clamp_o[head_core_i] <= 1'b0;
            cnt_q <= '0;
            st_q  <= SQ_UP_CLAMP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_UP_CLAMP: begin
          if (step_done) begin
            iso_o[head_core_i]    <= 1'b0;
            status_o[head_core_i] <= PWR_ON;
            st_q <= SQ_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 2,
  parameter int QUEUE_DEPTH       = 8,
  parameter int WAIT_W            = 8,
  parameter int WAIT_INIT         = 4,
  parameter int ADDR_W            = 4,
  parameter int DATA_W            = 32,
  localparam int NUM_CORES        = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_CORES-1:0] wfi_i,
  output logic [NUM_CORES-1:0] iso_o,
  output logic [NUM_CORES-1:0] clamp_o,
  output logic [NUM_CORES-1:0] pwr_en_o
);
  localparam int IDX_W = $clog2(NUM_CORES);

  logic [NUM_CORES-1:0][1:0] core_status;
  logic [NUM_CORES-1:0] core_hit, later_on;
  logic [IDX_W-1:0] head_core, wr_core;
  logic head_on, q_full, q_empty, pop;
  logic is_core, is_glb, code_ok, redundant, push;
  logic [1:0] req_val;
  logic [WAIT_W-1:0] wait_q;
  logic ovf_q;
  logic unused_wdata;

  assign is_core   = addr_i < ADDR_W'(NUM_CORES);
  assign is_glb    = addr_i == ADDR_W'(NUM_CORES);
  assign wr_core   = addr_i[IDX_W-1:0];
  assign req_val   = wdata_i[1:0];
  assign code_ok   = (req_val == PWR_ON) || (req_val == PWR_OFF);
  assign redundant = (core_status[wr_core] == req_val) && !core_hit[wr_core];
  assign push      = we_i && is_core && code_ok && !redundant;
  assign unused_wdata = ^wdata_i[DATA_W-1:WAIT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= WAIT_W'(WAIT_INIT);
      ovf_q  <= 1'b0;
    end else begin
      if (we_i && is_glb) wait_q <= wdata_i[WAIT_W-1:0];
      if (push && q_full) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_core) begin
      rdata_o[1:0] = core_status[wr_core];
    end else if (is_glb) begin
      rdata_o[WAIT_W-1:0] = wait_q;
      rdata_o[WAIT_W]     = ovf_q;
    end
  end

  core_pwr_queue #(
    .NUM_CORES(NUM_CORES), .DEPTH(QUEUE_DEPTH), .IDX_W(IDX_W)
  ) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_core_i (wr_core),
    .push_on_i   (req_val == PWR_ON),
    .pop_i       (pop),
    .full_o      (q_full),
    .empty_o     (q_empty),
    .head_core_o (head_core),
    .head_on_o   (head_on),
    .core_hit_o  (core_hit),
    .later_on_o  (later_on)
  );

  core_pwr_fsm #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .WAIT_W(WAIT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_empty_i   (q_empty),
    .head_core_i (head_core),
    .head_on_i   (head_on),
    .later_on_i  (later_on),
    .wfi_i       (wfi_i),
    .wait_i      (wait_q),
    .pop_o       (pop),
    .status_o    (core_status),
    .iso_o       (iso_o),
    .clamp_o     (clamp_o),
    .pwr_en_o    (pwr_en_o)
  );
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CORES-1:0]      wfi_i,
  input logic [NUM_CORES-1:0]      iso_o,
  input logic [NUM_CORES-1:0]      clamp_o,
  input logic [NUM_CORES-1:0]      pwr_en_o,
  input logic [NUM_CORES-1:0][1:0] core_status,
  input logic                      ovf_q
);
  logic [NUM_CORES-1:0] busy;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign busy[c] = core_status[c][0] ^ core_status[c][1];

    // R3
    iso_after_wfi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iso_o[c]) |-> $past(wfi_i[c]));

    // R4
    switch_open_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_en_o[c]) |-> (iso_o[c] && clamp_o[c]));

    // R4
    off_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_status[c] == 2'b00) |-> (!pwr_en_o[c] && iso_o[c] && clamp_o[c]));

    // R5
    iso_release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(iso_o[c]) |-> (pwr_en_o[c] && !clamp_o[c] && core_status[c] == 2'b11));

    // R5
    on_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_status[c] == 2'b11) |-> (pwr_en_o[c] && !iso_o[c] && !clamp_o[c]));
  end

  // R6
  single_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy) <= 1);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_q) |-> ovf_q);
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wfi_i       (wfi_i),
  .iso_o       (iso_o),
  .clamp_o     (clamp_o),
  .pwr_en_o    (pwr_en_o),
  .core_status (core_status),
  .ovf_q       (ovf_q)
);

// File: tb/core_pwr_seq_tb.sv
`timescale 1ns/1ps
module core_pwr_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  wfi_i = '0;
  logic [3:0]  iso_o, clamp_o, pwr_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int   m_status [4];
  logic [3:0] m_iso, m_clamp, m_pwr;
  bit   m_ovf;
  int   m_wait;
  int   mq [$];
  int   m_st;
  int   m_left;

  core_pwr_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wfi_i(wfi_i),
    .iso_o(iso_o), .clamp_o(clamp_o), .pwr_en_o(pwr_en_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_status[i] = 3;
    m_iso = '0; m_clamp = '0; m_pwr = '1;
    m_ovf = 0; m_wait = 4; mq.delete(); m_st = 0; m_left = 0;
  endtask

  function automatic bit has_entry(input int c);
    for (int i = 0; i < mq.size(); i++) if (mq[i] / 2 == c) return 1;
    return 0;
  endfunction

  task automatic step_model();
    bit do_push;
    int pv, c, on, weff;
    bit cancel;
    do_push = 0; pv = 0; c = 0; on = 0;
    if (we_i && addr_i < 4 && (wdata_i[1:0] == 2'd0 || wdata_i[1:0] == 2'd3)) begin
      int wc, tgt;
      wc = int'(addr_i); tgt = int'(wdata_i[1:0]);
      if (!(m_status[wc] == tgt && !has_entry(wc))) begin
        if (mq.size() >= 8) m_ovf = 1;
        else begin do_push = 1; pv = wc * 2 + (tgt == 3 ? 1 : 0); end
      end
    end
    weff = (m_wait < 1) ? 1 : m_wait;
    if (mq.size() > 0) begin c = mq[0] / 2; on = mq[0] % 2; end
    case (m_st)
      0: if (mq.size() > 0) begin
           if (m_status[c] == (on ? 3 : 0)) void'(mq.pop_front());
           else if (on == 0) m_st = 1;
           else begin m_status[c] = 1; m_pwr[c] = 1; m_left = weff; m_st = 5; end
         end
      1: begin
           cancel = 0;
           for (int i = 1; i < mq.size(); i++) if (mq[i] == c * 2 + 1) cancel = 1;
           if (cancel) begin void'(mq.pop_front()); m_st = 0; end
           else if (wfi_i[c]) begin m_status[c] = 2; m_iso[c] = 1; m_left = weff; m_st = 2; end
         end
      2: begin m_left--; if (m_left == 0) begin m_clamp[c] = 1; m_left = weff; m_st = 3; end end
      3: begin m_left--; if (m_left == 0) begin m_pwr[c] = 0; m_left = weff; m_st = 4; end end
      4: begin m_left--; if (m_left == 0) begin m_status[c] = 0; void'(mq.pop_front()); m_st = 0; end end
      5: begin m_left--; if (m_left == 0) begin m_clamp[c] = 0; m_left = weff; m_st = 6; end end
      6: begin m_left--; if (m_left == 0) begin
           m_iso[c] = 0; m_status[c] = 3; void'(mq.pop_front()); m_st = 0; end end
      default: m_st = 0;
    endcase
    if (do_push) mq.push_back(pv);
    if (we_i && addr_i == 4) m_wait = int'(wdata_i[7:0]);
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a < 4) return 32'(m_status[a]);
    if (a == 4) return {23'd0, m_ovf, 8'(m_wait)};
    return 32'd0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else step_model();
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(cur_req, "model pwr_en", {28'd0, pwr_en_o}, {28'd0, m_pwr});
      chk(cur_req, "model iso",    {28'd0, iso_o},    {28'd0, m_iso});
      chk(cur_req, "model clamp",  {28'd0, clamp_o},  {28'd0, m_clamp});
      chk(cur_req, "model rdata",  rdata_o, exp_rd(addr_i));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk_i); #2; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(posedge clk_i); #2; addr_i = a;
    @(negedge clk_i);
    chk(req, "rdata", rdata_o, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic set_wfi(input logic [3:0] v);
    @(posedge clk_i); #2; wfi_i = v;
  endtask

  function automatic logic [3:0] idx(input int cl, input int co);
    return 4'(cl * 2 + co);
  endfunction

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog %s act=running exp=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    idle(3);
    #2 rst_ni = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int i = 0; i < 4; i++) rd(4'(i), 32'h3, "R1");
    rd(4'd4, 32'h004, "R1");
    chk("R1", "pwr_en", {28'd0, pwr_en_o}, 32'hF);
    chk("R1", "iso",    {28'd0, iso_o},    32'h0);
    chk("R1", "clamp",  {28'd0, clamp_o},  32'h0);

    // R10 wait register
    cur_req = "R10";
    wr(4'd4, 32'h2);
    rd(4'd4, 32'h002, "R10");

    // R3 power-off held until WFI
    cur_req = "R3";
    wr(idx(1, 0), 32'h0);
    idle(10);
    rd(idx(1, 0), 32'h3, "R3");
    chk("R3", "iso2", {31'd0, iso_o[2]}, 32'h0);
    chk("R3", "pwr2", {31'd0, pwr_en_o[2]}, 32'h1);

    // R4 power-down sequence
    cur_req = "R4";
    set_wfi(4'b0100);
    rd(4'd2, 32'h2, "R4");
    idle(12);
    rd(4'd2, 32'h0, "R4");
    chk("R4", "pwr2",   {31'd0, pwr_en_o[2]}, 32'h0);
    chk("R4", "iso2",   {31'd0, iso_o[2]},    32'h1);
    chk("R4", "clamp2", {31'd0, clamp_o[2]},  32'h1);
    set_wfi(4'b0000);

    // R5 power-up sequence
    cur_req = "R5";
    wr(4'd2, 32'h3);
    rd(4'd2, 32'h1, "R5");
    idle(10);
    rd(4'd2, 32'h3, "R5");
    chk("R5", "pwr",   {28'd0, pwr_en_o}, 32'hF);
    chk("R5", "iso",   {28'd0, iso_o},    32'h0);
    chk("R5", "clamp", {28'd0, clamp_o},  32'h0);

    // R2 illegal codes ignored, unmapped address reads zero
    cur_req = "R2";
    wr(4'd1, 32'h1);
    wr(4'd2, 32'h2);
    idle(5);
    rd(4'd1, 32'h3, "R2");
    rd(idx(1, 0), 32'h3, "R2");
    chk("R2", "pwr", {28'd0, pwr_en_o}, 32'hF);
    rd(4'd5, 32'h0, "R2");

    // R6 strict ordering across cores
    cur_req = "R6";
    set_wfi(4'b0001);
    wr(4'd2, 32'h0);
    wr(4'd0, 32'h0);
    idle(8);
    rd(4'd0, 32'h3, "R6");
    rd(4'd2, 32'h3, "R6");
    set_wfi(4'b0101);
    idle(20);
    rd(4'd2, 32'h0, "R6");
    rd(4'd0, 32'h0, "R6");
    wr(4'd0, 32'h3);
    wr(4'd2, 32'h3);
    idle(20);
    rd(4'd0, 32'h3, "R6");
    rd(4'd2, 32'h3, "R6");
    set_wfi(4'b0000);

    // R9 cancel of a held power-off
    cur_req = "R9";
    wr(4'd0, 32'h0);
    idle(5);
    wr(4'd0, 32'h3);
    idle(5);
    rd(4'd0, 32'h3, "R9");
    chk("R9", "iso0", {31'd0, iso_o[0]},    32'h0);
    chk("R9", "pwr0", {31'd0, pwr_en_o[0]}, 32'h1);
    set_wfi(4'b0001);
    idle(10);
    rd(4'd0, 32'h3, "R9");
    chk("R9", "iso0 after wfi", {31'd0, iso_o[0]}, 32'h0);
    set_wfi(4'b0000);

    // R7 / R8 full queue, redundant writes, overflow
    cur_req = "R7";
    wr(4'd3, 32'h0);
    for (int k = 0; k < 3; k++) begin
      wr(4'd1, 32'h0);
      wr(4'd1, 32'h3);
    end
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h3);
    wr(4'd0, 32'h3);
    rd(4'd4, 32'h002, "R7");
    cur_req = "R8";
    wr(4'd0, 32'h0);
    rd(4'd4, 32'h102, "R8");
    set_wfi(4'b1010);
    idle(80);
    rd(4'd3, 32'h0, "R8");
    rd(4'd1, 32'h0, "R6");
    rd(4'd0, 32'h3, "R8");
    chk("R8", "pwr0", {31'd0, pwr_en_o[0]}, 32'h1);

    // R4 R5 with zero wait
    cur_req = "R10";
    wr(4'd4, 32'h0);
    rd(4'd4, 32'h100, "R10");
    cur_req = "R5";
    wr(4'd1, 32'h3);
    idle(10);
    rd(4'd1, 32'h3, "R5");
    wr(4'd3, 32'h3);
    idle(10);
    rd(4'd3, 32'h3, "R5");
    chk("R5", "pwr all", {28'd0, pwr_en_o}, 32'hF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule